// File: doc/BRIEF.md
# Source-Routed Connection Switch Node

This block is the communication switch of one node in a two-dimensional mesh. It has four link inputs and four link outputs (north, south, east, west) plus a local inject input and a local eject output. Words move on each link under a valid/ready handshake. Each word carries a kind, a logical channel number and a 32-bit payload. A sender opens a circuit-like connection by sending a header whose payload lists the hops to take. At each node the switch reads the lowest hop code, opens a connection toward that output, and forwards the header with the remaining hops shifted down. Every open connection holds one slot from a shared pool, and the slot number is the channel number used on the outgoing link.

After a connection is open, data and delimiter words on the same incoming channel follow it unchanged. A teardown word travels along the same path and frees the connection and its slot behind it. When several connections leave through the same physical link, they take turns word by word, so no software has to schedule them. A header that asks for a turn between the X and Y axes is refused. A header that finds the pool empty waits on its link until a slot is freed.

Top module: `mesh_route_node`

## Requirements
- R1: After reset every tx_valid bit is 0, turn_reject is 0, and no connection is open. With no rx_valid asserted, rx_ready is 0.
- R2: A header is routed to the output named by payload bits [2:0]. The hop codes are N=0, S=1, E=2, W=3, local=4, and they match the port indices. The forwarded header keeps kind 0, its payload is shifted right by 3 with zeros filled in, and its tx_chan is the allocated slot. The header leaves in the same cycle it is accepted.
- R3: Inputs N and S may reach only N, S or local. Inputs E and W may reach only E, W or local. The local input may reach any output. Hop codes 5 to 7 are invalid. A refused header, or a header on a channel that is already open, is consumed and raises turn_reject for that input for one cycle, and nothing appears on any output.
- R4: The pool has 20 slots. Slots 0 and 1 are never allocated. A header takes the lowest free slot from 2 to 19, so at most 18 connections can be open at once.
- R5: When no slot is free, a valid header keeps rx_ready low and produces no output. It goes through in the first cycle after a teardown frees a slot.
- R6: Data words (kind 1) and delimiter words (kind 2) on an open channel go to that connection's output with the same kind and payload, tx_chan equal to its slot, and in the order they arrived.
- R7: A teardown word (kind 3) is forwarded like data. Its connection is then closed, and its slot is free again from the next cycle on.
- R8: A non-header word on a channel that is not open is consumed (rx_ready is 1) and produces no output.
- R9: Inputs that compete for one output are served round-robin, one word per cycle. After a grant to input g, priority starts at input g+1.
- R10: While tx_ready of the target output is 0, the word stays offered, rx_ready of its input is 0, and nothing is lost.
- R11: At most one header gains a slot per cycle. Among routable headers, the lowest input index goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 5 | Word offered on each input (N,S,E,W,local) |
| rx_ready | output | 5 | Word accepted on each input |
| rx_kind | input | 10 | 2-bit kind per input: 0 header, 1 data, 2 delimiter, 3 teardown |
| rx_chan | input | 25 | 5-bit logical channel per input |
| rx_data | input | 160 | 32-bit payload per input |
| tx_valid | output | 5 | Word offered on each output (N,S,E,W,local) |
| tx_ready | input | 5 | Downstream accepts the word |
| tx_kind | output | 10 | 2-bit kind per output |
| tx_chan | output | 25 | 5-bit outgoing channel (slot number) per output |
| tx_data | output | 160 | 32-bit payload per output |
| turn_reject | output | 5 | One-cycle pulse per input when its header is refused |

## Verification
The hardest state to reach from the ports is a full pool with a header waiting on one link while a teardown arrives on a different link in the same cycle. The local input cannot free a slot while its own link is blocked by the stalled header. The bench opens seventeen connections from the local input to the eject port and one from the east input, then parks a header on the local input. It then sends a teardown on the east link and checks that the freed slot, 19, goes to the waiting header in the following cycle. Round-robin order is checked by holding two inputs valid toward one output, starting from a known last-grant state.

// File: rtl/swn_pkg.sv
package swn_pkg;
  localparam int NPORT = 5;
  localparam int KW = 2;
  localparam int HOP_W = 3;
  localparam int P_N = 0;
  localparam int P_S = 1;
  localparam int P_E = 2;
  localparam int P_W = 3;
  localparam int P_L = 4;

  typedef enum logic [KW-1:0] {
    K_HDR   = 2'd0,
    K_DATA  = 2'd1,
    K_DELIM = 2'd2,
    K_TEAR  = 2'd3
  } kind_e;

  // Axis rule: Y inputs stay on Y, X inputs stay on X, local is free.
  function automatic logic turn_ok(input int src, input logic [HOP_W-1:0] hop);
    int d;
    d = int'(hop);
    if (d > P_L) return 1'b0;
    if (d == P_L || src == P_L) return 1'b1;
    if (src <= P_S) return (d <= P_S);
    return (d == P_E || d == P_W);
  endfunction

  // Index of the lowest set bit, NPORT when none.
  function automatic int lowest_set(input logic [NPORT-1:0] v);
    for (int i = 0; i < NPORT; i++)
      if (v[i]) return i;
    return NPORT;
  endfunction
endpackage

// File: rtl/swn_rr_arb.sv
module swn_rr_arb #(
  parameter int N = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         advance,
  output logic [N-1:0] grant
);
  logic [IW-1:0] last_q;
  logic [IW-1:0] gidx;

  always_comb begin
    grant = '0;
    gidx  = last_q;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = int'(last_q) + k;
      if (idx >= N) idx = idx - N;
      if (req[idx] && grant == '0) begin
        grant[idx] = 1'b1;
        gidx = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= IW'(N - 1);
    else if (advance) last_q <= gidx;
  end

  p_grant_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_grant_has_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);
  p_work_conserving_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> (grant != '0));
endmodule

// File: rtl/swn_slot_pool.sv
module swn_slot_pool #(
  parameter int POOL  = 20,
  parameter int RSV   = 2,
  parameter int NFREE = 5,
  localparam int SW = $clog2(POOL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  output logic [SW-1:0]     alloc_idx,
  output logic              any_free,
  input  logic [NFREE-1:0]  free_en,
  input  logic [NFREE*SW-1:0] free_idx
);
  logic [POOL-1:0] used_q, avail, take, give;

  always_comb begin
    avail = '0;
    for (int s = 0; s < POOL; s++) avail[s] = (s >= RSV) && !used_q[s];
    any_free  = |avail;
    alloc_idx = '0;
    for (int s = POOL - 1; s >= 0; s--)
      if (avail[s]) alloc_idx = SW'(s);
    take = '0;
    if (alloc_en) take[alloc_idx] = 1'b1;
    give = '0;
    for (int f = 0; f < NFREE; f++)
      if (free_en[f]) give[free_idx[f*SW +: SW]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) used_q <= '0;
    else used_q <= (used_q | take) & ~give;
  end

  p_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(used_q) <= POOL - RSV);
  p_no_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> (int'(alloc_idx) >= RSV));
  p_alloc_needs_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> any_free);

  for (genvar f = 0; f < NFREE; f++) begin : g_free_chk
    p_free_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      free_en[f] |-> used_q[free_idx[f*SW +: SW]]);
    p_free_returns_r7: assert property (@(posedge clk) disable iff (!rst_n)
      free_en[f] |=> !used_q[$past(free_idx[f*SW +: SW])]);
  end
endmodule

// File: rtl/swn_conn_table.sv
module swn_conn_table #(
  parameter int NIN    = 5,
  parameter int CW     = 5,
  parameter int PORT_W = 3,
  parameter int SLOT_W = 5,
  localparam int NCH = 1 << CW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NIN*CW-1:0]     rd_chan,
  output logic [NIN-1:0]        rd_hit,
  output logic [NIN*PORT_W-1:0] rd_port,
  output logic [NIN*SLOT_W-1:0] rd_slot,
  input  logic                  set_en,
  input  logic [PORT_W-1:0]     set_src,
  input  logic [CW-1:0]         set_chan,
  input  logic [PORT_W-1:0]     set_port,
  input  logic [SLOT_W-1:0]     set_slot,
  input  logic [NIN-1:0]        clr_en,
  input  logic [NIN*CW-1:0]     clr_chan
);
  logic              open_q [NIN][NCH];
  logic [PORT_W-1:0] port_q [NIN][NCH];
  logic [SLOT_W-1:0] slot_q [NIN][NCH];

  always_comb begin
    for (int s = 0; s < NIN; s++) begin
      rd_hit[s]                  = open_q[s][rd_chan[s*CW +: CW]];
      rd_port[s*PORT_W +: PORT_W] = port_q[s][rd_chan[s*CW +: CW]];
      rd_slot[s*SLOT_W +: SLOT_W] = slot_q[s][rd_chan[s*CW +: CW]];
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < NIN; s++) begin
      for (int c = 0; c < NCH; c++) begin
        if (!rst_n) begin
          open_q[s][c] <= 1'b0;
          port_q[s][c] <= '0;
          slot_q[s][c] <= '0;
        end else if (set_en && set_src == PORT_W'(s) && set_chan == CW'(c)) begin
          open_q[s][c] <= 1'b1;
          port_q[s][c] <= set_port;
          slot_q[s][c] <= set_slot;
        end else if (clr_en[s] && clr_chan[s*CW +: CW] == CW'(c)) begin
          open_q[s][c] <= 1'b0;
        end
      end
    end
  end

  p_set_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !open_q[set_src][set_chan]);

  for (genvar s = 0; s < NIN; s++) begin : g_clr_chk
    p_clr_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en[s] |-> open_q[s][clr_chan[s*CW +: CW]]);
    p_clr_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en[s] |=> !open_q[s][$past(clr_chan[s*CW +: CW])]);
  end
endmodule

// File: rtl/mesh_route_node.sv
module mesh_route_node
  import swn_pkg::*;
#(
  parameter int PW   = 32,
  parameter int CW   = 5,
  parameter int POOL = 20,
  parameter int RSV  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPORT-1:0]    rx_valid,
  output logic [NPORT-1:0]    rx_ready,
  input  logic [NPORT*KW-1:0] rx_kind,
  input  logic [NPORT*CW-1:0] rx_chan,
  input  logic [NPORT*PW-1:0] rx_data,
  output logic [NPORT-1:0]    tx_valid,
  input  logic [NPORT-1:0]    tx_ready,
  output logic [NPORT*KW-1:0] tx_kind,
  output logic [NPORT*CW-1:0] tx_chan,
  output logic [NPORT*PW-1:0] tx_data,
  output logic [NPORT-1:0]    turn_reject
);
  localparam int SW     = $clog2(POOL);
  localparam int PORT_W = $clog2(NPORT);

  function automatic logic [PW-1:0] hop_pop(input logic [PW-1:0] p);
    return p >> HOP_W;
  endfunction

  // Per-input view of the head word
  logic [KW-1:0]     k_i   [NPORT];
  logic [CW-1:0]     c_i   [NPORT];
  logic [PW-1:0]     d_i   [NPORT];
  logic [HOP_W-1:0]  hop_i [NPORT];
  logic [PORT_W-1:0] tgt_i [NPORT];
  logic [PORT_W-1:0] tport_i [NPORT];
  logic [SW-1:0]     tslot_i [NPORT];
  logic [NPORT-1:0]  is_hdr, tv, hdr_ok, rej, drop, hdr_go, req_ok, fire_in, tear_fire;
  logic [NPORT-1:0]  req_mat [NPORT];
  logic [NPORT-1:0]  gnt     [NPORT];

  // Named internal events
  logic              pick_vld;
  logic [PORT_W-1:0] pick_idx;
  logic              alloc_en, any_free;
  logic [SW-1:0]     alloc_idx;
  logic [NPORT*PORT_W-1:0] rd_port;
  logic [NPORT*SW-1:0]     rd_slot, free_idx;

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      k_i[i]     = rx_kind[i*KW +: KW];
      c_i[i]     = rx_chan[i*CW +: CW];
      d_i[i]     = rx_data[i*PW +: PW];
      hop_i[i]   = d_i[i][HOP_W-1:0];
      tport_i[i] = rd_port[i*PORT_W +: PORT_W];
      tslot_i[i] = rd_slot[i*SW +: SW];
      is_hdr[i]  = (k_i[i] == K_HDR);
      hdr_ok[i]  = rx_valid[i] && is_hdr[i] && !tv[i] && turn_ok(i, hop_i[i]);
      rej[i]     = rx_valid[i] && is_hdr[i] && (tv[i] || !turn_ok(i, hop_i[i]));
      drop[i]    = rx_valid[i] && !is_hdr[i] && !tv[i];
      tgt_i[i]   = is_hdr[i] ? PORT_W'(hop_i[i]) : tport_i[i];
    end
    pick_vld = |hdr_ok;
    pick_idx = PORT_W'(lowest_set(hdr_ok));
    hdr_go   = '0;
    for (int i = 0; i < NPORT; i++)
      hdr_go[i] = pick_vld && any_free && (pick_idx == PORT_W'(i));
    for (int i = 0; i < NPORT; i++)
      req_ok[i] = hdr_go[i] || (rx_valid[i] && !is_hdr[i] && tv[i]);
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        req_mat[o][i] = req_ok[i] && (tgt_i[i] == PORT_W'(o));
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    swn_rr_arb #(.N(NPORT)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req_mat[o]),
      .advance ((|gnt[o]) && tx_ready[o]),
      .grant   (gnt[o])
    );
  end

  always_comb begin
    fire_in = '0;
    tx_kind = '0;
    tx_chan = '0;
    tx_data = '0;
    for (int o = 0; o < NPORT; o++) begin
      tx_valid[o] = |gnt[o];
      for (int i = 0; i < NPORT; i++) begin
        if (gnt[o][i]) begin
          tx_kind[o*KW +: KW] = k_i[i];
          tx_chan[o*CW +: CW] = is_hdr[i] ? CW'(alloc_idx) : CW'(tslot_i[i]);
          tx_data[o*PW +: PW] = is_hdr[i] ? hop_pop(d_i[i]) : d_i[i];
          fire_in[i] = fire_in[i] | tx_ready[o];
        end
      end
    end
    rx_ready    = fire_in | drop | rej;
    turn_reject = rej;
    tear_fire   = '0;
    free_idx    = '0;
    for (int i = 0; i < NPORT; i++) begin
      tear_fire[i] = fire_in[i] && (k_i[i] == K_TEAR);
      free_idx[i*SW +: SW] = tslot_i[i];
    end
    alloc_en = |(hdr_go & fire_in);
  end

  swn_slot_pool #(.POOL(POOL), .RSV(RSV), .NFREE(NPORT)) u_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (alloc_en),
    .alloc_idx (alloc_idx),
    .any_free  (any_free),
    .free_en   (tear_fire),
    .free_idx  (free_idx)
  );

  swn_conn_table #(.NIN(NPORT), .CW(CW), .PORT_W(PORT_W), .SLOT_W(SW)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_chan  (rx_chan),
    .rd_hit   (tv),
    .rd_port  (rd_port),
    .rd_slot  (rd_slot),
    .set_en   (alloc_en),
    .set_src  (pick_idx),
    .set_chan (c_i[pick_idx]),
    .set_port (PORT_W'(hop_i[pick_idx])),
    .set_slot (alloc_idx),
    .clr_en   (tear_fire),
    .clr_chan (rx_chan)
  );

  p_one_alloc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hdr_go & fire_in) <= 1);

  for (genvar i = 0; i < NPORT; i++) begin : g_in_chk
    p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid[i] && k_i[i] == K_HDR && !turn_reject[i] && !any_free) |-> !rx_ready[i]);
    p_reject_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      turn_reject[i] |-> !fire_in[i]);
    p_drop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      drop[i] |-> !req_ok[i]);
    p_backpressure_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ok[i] && !fire_in[i]) |-> !rx_ready[i]);
  end

  for (genvar o = 0; o < P_L; o++) begin : g_axis_o
    for (genvar i = 0; i < P_L; i++) begin : g_axis_i
      if ((o <= P_S) != (i <= P_S)) begin : g_cross
        p_axis_r3: assert property (@(posedge clk) disable iff (!rst_n)
          !gnt[o][i]);
      end
    end
  end
endmodule

// File: tb/mesh_route_node_bench.sv
module mesh_route_node_bench;
  localparam int PW = 32;
  localparam int CW = 5;
  localparam int NP = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NP-1:0]    rx_valid = '0;
  logic [NP-1:0]    rx_ready;
  logic [NP*2-1:0]  rx_kind = '0;
  logic [NP*CW-1:0] rx_chan = '0;
  logic [NP*PW-1:0] rx_data = '0;
  logic [NP-1:0]    tx_valid;
  logic [NP-1:0]    tx_ready = '1;
  logic [NP*2-1:0]  tx_kind;
  logic [NP*CW-1:0] tx_chan;
  logic [NP*PW-1:0] tx_data;
  logic [NP-1:0]    turn_reject;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  mesh_route_node u_mesh_route_node (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_kind(rx_kind),
    .rx_chan(rx_chan), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_kind(tx_kind),
    .tx_chan(tx_chan), .tx_data(tx_data), .turn_reject(turn_reject)
  );

  // kinds: 0 header, 1 data, 2 delimiter, 3 teardown; ports N0 S1 E2 W3 L4
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint word_at(input int o);
    return (longint'(tx_kind[o*2 +: 2]) << 40) | (longint'(tx_chan[o*CW +: CW]) << 32)
           | longint'(tx_data[o*PW +: PW]);
  endfunction

  function automatic longint pack(input int k, input int c, input logic [31:0] d);
    return (longint'(k) << 40) | (longint'(c) << 32) | longint'(d);
  endfunction

  task automatic drive(input int p, input int k, input int c, input logic [31:0] d);
    rx_valid[p] = 1'b1;
    rx_kind[p*2 +: 2] = 2'(k);
    rx_chan[p*CW +: CW] = CW'(c);
    rx_data[p*PW +: PW] = d;
  endtask

  // one word expected at output op in the cycle it is offered
  task automatic xfer(input int p, input int k, input int c, input logic [31:0] d,
                      input int op, input int ek, input int ec, input logic [31:0] ed,
                      input string tag);
    @(negedge clk);
    drive(p, k, c, d);
    #1;
    chk(rx_ready[p] == 1'b1, {tag, " accept"}, rx_ready[p], 1);
    chk(tx_valid[op] == 1'b1 && word_at(op) == pack(ek, ec, ed), {tag, " word"},
        tx_valid[op] ? word_at(op) : -1, pack(ek, ec, ed));
    @(posedge clk);
    #1 rx_valid[p] = 1'b0;
  endtask

  // word consumed with no output; rj = expected turn_reject bit
  task automatic xfer_gone(input int p, input int k, input int c, input logic [31:0] d,
                           input bit rj, input string tag);
    @(negedge clk);
    drive(p, k, c, d);
    #1;
    chk(rx_ready[p] == 1'b1, {tag, " consumed"}, rx_ready[p], 1);
    chk(tx_valid == '0, {tag, " no output"}, tx_valid, 0);
    chk(turn_reject[p] == rj, {tag, " reject flag"}, turn_reject[p], rj);
    @(posedge clk);
    #1 rx_valid[p] = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(tx_valid == '0, "R1 tx_valid idle", tx_valid, 0);
    chk(rx_ready == '0, "R1 rx_ready idle", rx_ready, 0);
    chk(turn_reject == '0, "R1 no reject", turn_reject, 0);
  endtask

  task automatic t_open();
    // W input, channel 1, hops E then local: payload bits [2:0]=2, [5:3]=4
    xfer(3, 0, 1, 32'h0000_0022, 2, 0, 2, 32'h0000_0004, "R2 R4 open W->E first slot 2");
  endtask

  task automatic t_stream();
    xfer(3, 1, 1, 32'h1111_0001, 2, 1, 2, 32'h1111_0001, "R6 data 1");
    xfer(3, 2, 1, 32'hD000_0001, 2, 2, 2, 32'hD000_0001, "R6 delim 1");
    xfer(3, 1, 1, 32'h2222_0002, 2, 1, 2, 32'h2222_0002, "R6 data 2");
    xfer(3, 2, 1, 32'hD000_0002, 2, 2, 2, 32'hD000_0002, "R6 delim 2");
  endtask

  task automatic t_turn();
    xfer_gone(0, 0, 2, 32'h2, 1'b1, "R3 N input to E refused");
    xfer_gone(2, 0, 2, 32'h0, 1'b1, "R3 E input to N refused");
    xfer_gone(4, 0, 2, 32'h6, 1'b1, "R3 hop code 6 refused");
    xfer_gone(3, 0, 1, 32'h2, 1'b1, "R3 header on open channel refused");
  endtask

  task automatic t_closed();
    xfer_gone(0, 1, 5, 32'hBAD0_0001, 1'b0, "R8 data on closed channel");
    xfer_gone(0, 2, 5, 32'hBAD0_0002, 1'b0, "R8 delim on closed channel");
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    tx_ready[2] = 1'b0;
    drive(3, 1, 1, 32'h5555_0000);
    #1;
    chk(rx_ready[3] == 1'b0, "R10 held while stalled", rx_ready[3], 0);
    chk(tx_valid[2] && word_at(2) == pack(1, 2, 32'h5555_0000), "R10 word offered",
        word_at(2), pack(1, 2, 32'h5555_0000));
    @(negedge clk);
    #1;
    chk(rx_ready[3] == 1'b0, "R10 still held", rx_ready[3], 0);
    @(negedge clk);
    tx_ready[2] = 1'b1;
    #1;
    chk(rx_ready[3] == 1'b1 && word_at(2) == pack(1, 2, 32'h5555_0000),
        "R10 delivered after release", word_at(2), pack(1, 2, 32'h5555_0000));
    @(posedge clk);
    #1 rx_valid[3] = 1'b0;
    @(negedge clk);
    chk(tx_valid == '0, "R10 no duplicate", tx_valid, 0);
  endtask

  task automatic t_teardown();
    xfer(3, 3, 1, 32'h0, 2, 3, 2, 32'h0, "R7 teardown forwarded");
    xfer_gone(3, 1, 1, 32'h7777_0000, 1'b0, "R7 R8 data after teardown dropped");
    xfer(3, 0, 3, 32'h2, 2, 0, 2, 32'h0, "R7 slot 2 reused");
    xfer(3, 3, 3, 32'h0, 2, 3, 2, 32'h0, "R7 second teardown");
  endtask

  task automatic t_exhaust();
    for (int k = 0; k < 17; k++)
      xfer(4, 0, k, 32'h4 | (k << 16), 4, 0, 2 + k, (32'h4 | (k << 16)) >> 3,
           "R4 fill pool");
    xfer(2, 0, 0, 32'h3, 3, 0, 19, 32'h0, "R4 last slot 19");
    @(negedge clk);
    drive(4, 0, 17, 32'h4);
    for (int n = 0; n < 3; n++) begin
      #1;
      chk(rx_ready[4] == 1'b0, "R5 header stalls on empty pool", rx_ready[4], 0);
      chk(tx_valid[4] == 1'b0, "R5 nothing ejected while stalled", tx_valid[4], 0);
      @(negedge clk);
    end
    drive(2, 3, 0, 32'h0);
    #1;
    chk(rx_ready[2] == 1'b1 && word_at(3) == pack(3, 19, 0), "R7 teardown on E frees 19",
        word_at(3), pack(3, 19, 0));
    chk(rx_ready[4] == 1'b0, "R5 still stalled in teardown cycle", rx_ready[4], 0);
    @(posedge clk);
    #1 rx_valid[2] = 1'b0;
    @(negedge clk);
    #1;
    chk(rx_ready[4] == 1'b1 && tx_valid[4] && word_at(4) == pack(0, 19, 0),
        "R5 header takes freed slot", word_at(4), pack(0, 19, 0));
    @(posedge clk);
    #1 rx_valid[4] = 1'b0;
    for (int k = 0; k < 18; k++)
      xfer(4, 3, k, 32'h0, 4, 3, (k < 17) ? 2 + k : 19, 32'h0, "R7 drain pool");
  endtask

  task automatic t_rr();
    int n0;
    int n4;
    xfer(0, 0, 0, 32'h1, 1, 0, 2, 32'h0, "R9 open N->S");
    xfer(4, 0, 0, 32'h1, 1, 0, 3, 32'h0, "R9 open L->S");
    n0 = 0;
    n4 = 0;
    for (int cyc = 0; cyc < 8; cyc++) begin
      @(negedge clk);
      if (n0 < 4) drive(0, 1, 0, 32'hA0 + n0); else rx_valid[0] = 1'b0;
      if (n4 < 4) drive(4, 1, 0, 32'hB0 + n4); else rx_valid[4] = 1'b0;
      #1;
      if (cyc % 2 == 0)
        chk(word_at(1) == pack(1, 2, 32'hA0 + cyc / 2), "R9 round-robin N turn",
            word_at(1), pack(1, 2, 32'hA0 + cyc / 2));
      else
        chk(word_at(1) == pack(1, 3, 32'hB0 + cyc / 2), "R9 round-robin L turn",
            word_at(1), pack(1, 3, 32'hB0 + cyc / 2));
      if (rx_ready[0]) n0++;
      if (rx_ready[4]) n4++;
    end
    @(posedge clk);
    #1 rx_valid = '0;
    xfer(0, 3, 0, 32'h0, 1, 3, 2, 32'h0, "R9 close N");
    xfer(4, 3, 0, 32'h0, 1, 3, 3, 32'h0, "R9 close L");
  endtask

  task automatic t_simul_hdr();
    @(negedge clk);
    drive(0, 0, 1, 32'h1);
    drive(4, 0, 1, 32'h0);
    #1;
    chk(rx_ready[0] == 1'b1 && rx_ready[4] == 1'b0, "R11 lower input first",
        rx_ready, 5'b00001);
    chk(word_at(1) == pack(0, 2, 0) && !tx_valid[0], "R11 first header slot 2",
        word_at(1), pack(0, 2, 0));
    @(posedge clk);
    #1 rx_valid[0] = 1'b0;
    @(negedge clk);
    #1;
    chk(rx_ready[4] == 1'b1 && tx_valid[0] && word_at(0) == pack(0, 3, 0),
        "R11 second header next cycle", word_at(0), pack(0, 3, 0));
    @(posedge clk);
    #1 rx_valid[4] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_open();
    t_stream();
    t_turn();
    t_closed();
    t_backpressure();
    t_teardown();
    t_exhaust();
    t_rr();
    t_simul_hdr();
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule